// File: doc/BRIEF.md
# Speech Converter Host-Side Buffer

This block sits between a peripheral bus and a delta-modulation (CVSD) / PCM speech converter core. On the host side, software or a DMA engine writes delta-modulated words into an input queue, drains converted delta words from an output queue, and exchanges linear PCM samples through two double-buffered registers. A sticky status word records the three events that need service. Each status flag can raise the interrupt line and a level DMA request, depending on its enables.

On the core side, the converter pulls delta bits one at a time from the input queue and pushes delta bits one at a time into the output queue. The block packs and unpacks the 16-bit words. The core also takes PCM samples from the input double buffer and hands samples to the output double buffer.

A freeze input, driven by an in-system emulator, stalls all core-side traffic. It also stops status reads from clearing the status flags, so a debugger can inspect the block without disturbing it.

Top module: `spch_host_buf`

## Requirements
- R1: The delta input queue holds DEPTH (8) words of DW (16) bits in arrival order. A host write while it is full is dropped and does not disturb the stored words.
- R2: The core reads each input word one bit at a time, starting at bit 0 and ending at bit 15. `core_cv_bit` shows the current bit, and `core_cv_bit_valid` is high while the queue holds a word. Accepting bit 15 retires the word.
- R3: Core output bits fill a word from bit 0 to bit 15. Each completed word enters the DEPTH-word output queue, which the host reads in order through `host_cvout_data`, and each `host_cvout_rd` removes the head. A read from an empty queue changes nothing.
- R4: PCM input is double-buffered. A host write lands in a staging register and reaches `core_pcm_in_data` with `core_pcm_in_valid` two clock edges later, provided the core-visible register is free. A second write waits in staging until the core takes the current sample.
- R5: PCM output is double-buffered. A core sample appears on `host_pcmout_data` two edges after it is delivered, if the host register is free. A newer sample waits in staging until `host_pcmout_rd`. After reset `host_pcmout_data` is zero.
- R6: The status bits are: bit 0 PCM flag, bit 1 input-empty flag, bit 2 output-full flag. The PCM flag is set when either double buffer moves its staged sample forward. The input-empty flag is set when the core retires the last word of the input queue. The output-full flag is set when a completed core word fills the output queue.
- R7: Status flags are sticky. A `host_stat_rd` with freeze low clears them at the next edge. Nothing else clears them.
- R8: While `freeze` is high, every core strobe is ignored: no bit leaves the input queue, no bit enters the output word, no PCM sample is taken or delivered, and `host_pcmout_data` is not updated.
- R9: While `freeze` is high, a status read leaves all flags set.
- R10: `irq` is high when the PCM flag is set with the PCM interrupt enabled, or when either delta flag is set with the delta interrupt enabled.
- R11: Each DMA request is a level: the PCM requests follow the PCM flag, the input request follows the input-empty flag, the output request follows the output-full flag, each gated by its own enable. The PCM interrupt must never be enabled with either PCM DMA enable, and the delta interrupt never with either delta DMA enable.
- R12: After reset all flags are clear, `irq` and all DMA requests are low, both queues are empty and `core_pcm_in_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| freeze | input | 1 | Emulator freeze: stalls core side, blocks flag clearing |
| cfg_pcm_irq_en | input | 1 | PCM flag interrupt enable |
| cfg_cv_irq_en | input | 1 | Delta flags interrupt enable |
| cfg_dma_pcm_in_en | input | 1 | PCM input DMA enable |
| cfg_dma_pcm_out_en | input | 1 | PCM output DMA enable |
| cfg_dma_cv_in_en | input | 1 | Delta input DMA enable |
| cfg_dma_cv_out_en | input | 1 | Delta output DMA enable |
| host_cvin_wr | input | 1 | Host write strobe to delta input queue |
| host_cvin_data | input | DW | Delta word written by host |
| host_cvout_rd | input | 1 | Host read strobe for delta output queue |
| host_cvout_data | output | DW | Head of delta output queue |
| host_pcmin_wr | input | 1 | Host write strobe for PCM input |
| host_pcmin_data | input | DW | PCM sample written by host |
| host_pcmout_rd | input | 1 | Host read strobe for PCM output |
| host_pcmout_data | output | DW | PCM sample for host |
| host_stat_rd | input | 1 | Host status read strobe |
| host_stat | output | 3 | Status flags |
| irq | output | 1 | Interrupt request |
| dma_pcm_in_req | output | 1 | PCM input DMA request |
| dma_pcm_out_req | output | 1 | PCM output DMA request |
| dma_cv_in_req | output | 1 | Delta input DMA request |
| dma_cv_out_req | output | 1 | Delta output DMA request |
| core_cv_bit_take | input | 1 | Core accepts current input bit |
| core_cv_bit | output | 1 | Current input delta bit |
| core_cv_bit_valid | output | 1 | Input queue holds a word |
| core_cv_bit_put | input | 1 | Core delivers an output bit |
| core_cv_bit_in | input | 1 | Output delta bit from core |
| core_pcm_take | input | 1 | Core takes the PCM input sample |
| core_pcm_in_data | output | DW | PCM input sample for core |
| core_pcm_in_valid | output | 1 | PCM input sample present |
| core_pcm_put | input | 1 | Core delivers a PCM output sample |
| core_pcm_out_data | input | DW | PCM output sample from core |

## Verification
The assertions assume that software never sets a legal-configuration-violating pair of enables, and that freeze and the strobes are synchronous single-cycle levels that are sampled only at rising edges. The stimulus walks only the twenty-five legal enable combinations, with the flags all set and then all clear. It changes every input at the falling edge, so each strobe is seen by exactly one rising edge. Freeze is raised only around core strobes and status reads, and the bench confirms afterwards that the stalled words and samples come out unchanged.

// File: rtl/spch_buf_pkg.sv
package spch_buf_pkg;
   localparam int unsigned ST_PCM = 0;
   localparam int unsigned ST_CVE = 1;
   localparam int unsigned ST_CVF = 2;
   localparam int unsigned ST_W   = 3;

   // Packed so that bit positions match ST_* indices
   typedef struct packed {
      logic cvf;
      logic cve;
      logic pcm;
   } stat_t;
endpackage

// File: rtl/spch_fifo.sv
module spch_fifo #(
   parameter int unsigned DW    = 16,
   parameter int unsigned DEPTH = 8
) (
   input  logic                                      clk,
   input  logic                                      rst_n,
   input  logic                                      push,
   input  logic [DW-1:0]                             wdata,
   input  logic                                      pop,
   output logic [DW-1:0]                             rdata,
   output logic [((DEPTH > 1) ? $clog2(DEPTH) : 1):0] level,
   output logic                                      full,
   output logic                                      empty
);
   localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int unsigned LW = AW + 1;

   logic [DW-1:0] mem [DEPTH];
   logic [AW-1:0] wp, rp, wp_nx, rp_nx;
   logic          do_push, do_pop;

   assign do_push = push & ~full;
   assign do_pop  = pop & ~empty;

   generate
      if ((1 << AW) == DEPTH) begin : g_pow2
         assign wp_nx = wp + 1'b1;
         assign rp_nx = rp + 1'b1;
      end else begin : g_wrap
         assign wp_nx = (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
         assign rp_nx = (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp    <= '0;
         rp    <= '0;
         level <= '0;
      end else begin
         if (do_push) wp <= wp_nx;
         if (do_pop)  rp <= rp_nx;
         if (do_push && !do_pop)      level <= level + 1'b1;
         else if (do_pop && !do_push) level <= level - 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (do_push) mem[wp] <= wdata;
   end

   assign rdata = mem[rp];
   assign full  = (level == LW'(DEPTH));
   assign empty = (level == '0);
endmodule

// File: rtl/spch_dbuf.sv
module spch_dbuf #(
   parameter int unsigned DW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          hold,
   input  logic          wr,
   input  logic [DW-1:0] wdata,
   input  logic          rd,
   output logic [DW-1:0] front,
   output logic          front_v,
   output logic          xfer
);
   logic [DW-1:0] stage_q;
   logic          stage_v;

   // Staged sample advances when the visible slot is free or being consumed
   assign xfer = stage_v & (~front_v | rd) & ~hold;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stage_q <= '0;
         stage_v <= 1'b0;
         front   <= '0;
         front_v <= 1'b0;
      end else begin
         if (wr) begin
            stage_q <= wdata;
            stage_v <= 1'b1;
         end else if (xfer) begin
            stage_v <= 1'b0;
         end
         if (xfer) begin
            front   <= stage_q;
            front_v <= 1'b1;
         end else if (rd) begin
            front_v <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/spch_host_buf.sv
module spch_host_buf
   import spch_buf_pkg::*;
#(
   parameter int unsigned DW    = 16,
   parameter int unsigned DEPTH = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            freeze,
   input  logic            cfg_pcm_irq_en,
   input  logic            cfg_cv_irq_en,
   input  logic            cfg_dma_pcm_in_en,
   input  logic            cfg_dma_pcm_out_en,
   input  logic            cfg_dma_cv_in_en,
   input  logic            cfg_dma_cv_out_en,
   input  logic            host_cvin_wr,
   input  logic [DW-1:0]   host_cvin_data,
   input  logic            host_cvout_rd,
   output logic [DW-1:0]   host_cvout_data,
   input  logic            host_pcmin_wr,
   input  logic [DW-1:0]   host_pcmin_data,
   input  logic            host_pcmout_rd,
   output logic [DW-1:0]   host_pcmout_data,
   input  logic            host_stat_rd,
   output logic [ST_W-1:0] host_stat,
   output logic            irq,
   output logic            dma_pcm_in_req,
   output logic            dma_pcm_out_req,
   output logic            dma_cv_in_req,
   output logic            dma_cv_out_req,
   input  logic            core_cv_bit_take,
   output logic            core_cv_bit,
   output logic            core_cv_bit_valid,
   input  logic            core_cv_bit_put,
   input  logic            core_cv_bit_in,
   input  logic            core_pcm_take,
   output logic [DW-1:0]   core_pcm_in_data,
   output logic            core_pcm_in_valid,
   input  logic            core_pcm_put,
   input  logic [DW-1:0]   core_pcm_out_data
);
   localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int unsigned LW = AW + 1;
   localparam int unsigned BW = (DW > 1) ? $clog2(DW) : 1;
   localparam logic [BW-1:0] BIT_LAST = BW'(DW - 1);
   localparam logic [LW-1:0] LVL_ONE  = LW'(1);
   localparam logic [LW-1:0] LVL_NEAR = LW'(DEPTH - 1);

   generate
      if (DW < 2) begin : g_bad_dw
         $error("spch_host_buf: DW must be at least 2");
      end
      if (DEPTH < 2) begin : g_bad_depth
         $error("spch_host_buf: DEPTH must be at least 2");
      end
   endgenerate

   // ---------------- delta input queue and bit serializer ----------------
   logic [DW-1:0] in_head;
   logic [LW-1:0] in_level;
   logic          in_full, in_empty, in_push, in_pop, take_ok;
   logic [BW-1:0] rd_idx;

   assign in_push = host_cvin_wr & ~in_full;
   assign take_ok = core_cv_bit_take & ~freeze & ~in_empty;
   assign in_pop  = take_ok & (rd_idx == BIT_LAST);

   spch_fifo #(.DW(DW), .DEPTH(DEPTH)) u_cvin (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (in_push),
      .wdata (host_cvin_data),
      .pop   (in_pop),
      .rdata (in_head),
      .level (in_level),
      .full  (in_full),
      .empty (in_empty)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       rd_idx <= '0;
      else if (take_ok) rd_idx <= (rd_idx == BIT_LAST) ? '0 : rd_idx + 1'b1;
   end

   assign core_cv_bit       = in_head[rd_idx];
   assign core_cv_bit_valid = ~in_empty;

   // ---------------- delta bit packer and output queue ----------------
   logic [DW-1:0] asm_q, asm_nx;
   logic [BW-1:0] wr_idx;
   logic [LW-1:0] out_level;
   logic          out_full, out_empty, out_push, out_pop, put_ok;

   assign put_ok = core_cv_bit_put & ~freeze;

   always_comb begin
      asm_nx         = asm_q;
      asm_nx[wr_idx] = core_cv_bit_in;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         asm_q  <= '0;
         wr_idx <= '0;
      end else if (put_ok) begin
         asm_q  <= asm_nx;
         wr_idx <= (wr_idx == BIT_LAST) ? '0 : wr_idx + 1'b1;
      end
   end

   assign out_push = put_ok & (wr_idx == BIT_LAST) & ~out_full;
   assign out_pop  = host_cvout_rd & ~out_empty;

   spch_fifo #(.DW(DW), .DEPTH(DEPTH)) u_cvout (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (out_push),
      .wdata (asm_nx),
      .pop   (out_pop),
      .rdata (host_cvout_data),
      .level (out_level),
      .full  (out_full),
      .empty (out_empty)
   );

   // ---------------- PCM double buffers ----------------
   logic pcmi_xfer, pcmo_xfer, pcmi_rd;

   assign pcmi_rd = core_pcm_take & ~freeze & core_pcm_in_valid;

   spch_dbuf #(.DW(DW)) u_pcmin (
      .clk     (clk),
      .rst_n   (rst_n),
      .hold    (1'b0),
      .wr      (host_pcmin_wr),
      .wdata   (host_pcmin_data),
      .rd      (pcmi_rd),
      .front   (core_pcm_in_data),
      .front_v (core_pcm_in_valid),
      .xfer    (pcmi_xfer)
   );

   logic pcmo_front_v;

   spch_dbuf #(.DW(DW)) u_pcmout (
      .clk     (clk),
      .rst_n   (rst_n),
      .hold    (freeze),
      .wr      (core_pcm_put & ~freeze),
      .wdata   (core_pcm_out_data),
      .rd      (host_pcmout_rd & pcmo_front_v),
      .front   (host_pcmout_data),
      .front_v (pcmo_front_v),
      .xfer    (pcmo_xfer)
   );

   // ---------------- sticky status and requests ----------------
   stat_t flg_q, flg_set;
   logic  clr;

   always_comb begin
      flg_set.pcm = pcmi_xfer | pcmo_xfer;
      flg_set.cve = in_pop & (in_level == LVL_ONE) & ~in_push;
      flg_set.cvf = out_push & (out_level == LVL_NEAR) & ~out_pop;
   end

   assign clr = host_stat_rd & ~freeze;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flg_q <= '0;
      else        flg_q <= flg_set | (clr ? stat_t'('0) : flg_q);
   end

   assign host_stat       = flg_q;
   assign irq             = (flg_q.pcm & cfg_pcm_irq_en) |
                            ((flg_q.cve | flg_q.cvf) & cfg_cv_irq_en);
   assign dma_pcm_in_req  = flg_q.pcm & cfg_dma_pcm_in_en;
   assign dma_pcm_out_req = flg_q.pcm & cfg_dma_pcm_out_en;
   assign dma_cv_in_req   = flg_q.cve & cfg_dma_cv_in_en;
   assign dma_cv_out_req  = flg_q.cvf & cfg_dma_cv_out_en;
endmodule

// File: rtl/spch_host_buf_chk.sv
module spch_host_buf_chk #(
   parameter int unsigned DW    = 16,
   parameter int unsigned DEPTH = 8
) (
   input logic                                      clk,
   input logic                                      rst_n,
   input logic                                      freeze,
   input logic                                      host_stat_rd,
   input logic [2:0]                                host_stat,
   input logic                                      irq,
   input logic                                      dma_pcm_in_req,
   input logic                                      dma_pcm_out_req,
   input logic                                      dma_cv_in_req,
   input logic                                      dma_cv_out_req,
   input logic                                      cfg_pcm_irq_en,
   input logic                                      cfg_cv_irq_en,
   input logic                                      cfg_dma_pcm_in_en,
   input logic                                      cfg_dma_pcm_out_en,
   input logic                                      cfg_dma_cv_in_en,
   input logic                                      cfg_dma_cv_out_en,
   input logic                                      core_cv_bit,
   input logic                                      core_cv_bit_valid,
   input logic [DW-1:0]                             host_pcmout_data,
   input logic [((DEPTH > 1) ? $clog2(DEPTH) : 1):0] in_level,
   input logic [((DEPTH > 1) ? $clog2(DEPTH) : 1):0] out_level
);
   localparam int unsigned LW = ((DEPTH > 1) ? $clog2(DEPTH) : 1) + 1;

   p_no_overflow_r1: assert property (@(posedge clk) disable iff (!rst_n)
      in_level <= LW'(DEPTH));

   p_out_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
      out_level <= LW'(DEPTH));

   p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !(host_stat_rd && !freeze) |=> ((host_stat & $past(host_stat)) == $past(host_stat)));

   p_frozen_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
      freeze |=> ((host_stat & $past(host_stat)) == $past(host_stat)));

   p_cvin_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (freeze && core_cv_bit_valid) |=> ($stable(core_cv_bit) && core_cv_bit_valid));

   p_pcmout_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
      freeze |=> $stable(host_pcmout_data));

   p_irq_src_r10: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (host_stat != 3'b000));

   p_dma_cv_src_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (dma_cv_in_req || dma_cv_out_req) |-> (host_stat[1] || host_stat[2]));

   p_dma_pcm_src_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (dma_pcm_in_req || dma_pcm_out_req) |-> host_stat[0]);

   p_cfg_legal_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !(cfg_pcm_irq_en && (cfg_dma_pcm_in_en || cfg_dma_pcm_out_en)) &&
      !(cfg_cv_irq_en && (cfg_dma_cv_in_en || cfg_dma_cv_out_en)));
endmodule

bind spch_host_buf spch_host_buf_chk #(.DW(DW), .DEPTH(DEPTH)) u_chk (
   .clk                (clk),
   .rst_n              (rst_n),
   .freeze             (freeze),
   .host_stat_rd       (host_stat_rd),
   .host_stat          (host_stat),
   .irq                (irq),
   .dma_pcm_in_req     (dma_pcm_in_req),
   .dma_pcm_out_req    (dma_pcm_out_req),
   .dma_cv_in_req      (dma_cv_in_req),
   .dma_cv_out_req     (dma_cv_out_req),
   .cfg_pcm_irq_en     (cfg_pcm_irq_en),
   .cfg_cv_irq_en      (cfg_cv_irq_en),
   .cfg_dma_pcm_in_en  (cfg_dma_pcm_in_en),
   .cfg_dma_pcm_out_en (cfg_dma_pcm_out_en),
   .cfg_dma_cv_in_en   (cfg_dma_cv_in_en),
   .cfg_dma_cv_out_en  (cfg_dma_cv_out_en),
   .core_cv_bit        (core_cv_bit),
   .core_cv_bit_valid  (core_cv_bit_valid),
   .host_pcmout_data   (host_pcmout_data),
   .in_level           (in_level),
   .out_level          (out_level)
);

// File: tb/tb_spch_host_buf.sv
module tb_spch_host_buf;
   localparam int DW = 16;
   localparam int DEPTH = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic freeze = 1'b0;
   logic cfg_pcm_irq_en = 1'b0, cfg_cv_irq_en = 1'b0;
   logic cfg_dma_pcm_in_en = 1'b0, cfg_dma_pcm_out_en = 1'b0;
   logic cfg_dma_cv_in_en = 1'b0, cfg_dma_cv_out_en = 1'b0;
   logic host_cvin_wr = 1'b0;
   logic [DW-1:0] host_cvin_data = '0;
   logic host_cvout_rd = 1'b0;
   logic [DW-1:0] host_cvout_data;
   logic host_pcmin_wr = 1'b0;
   logic [DW-1:0] host_pcmin_data = '0;
   logic host_pcmout_rd = 1'b0;
   logic [DW-1:0] host_pcmout_data;
   logic host_stat_rd = 1'b0;
   logic [2:0] host_stat;
   logic irq, dma_pcm_in_req, dma_pcm_out_req, dma_cv_in_req, dma_cv_out_req;
   logic core_cv_bit_take = 1'b0;
   logic core_cv_bit, core_cv_bit_valid;
   logic core_cv_bit_put = 1'b0, core_cv_bit_in = 1'b0;
   logic core_pcm_take = 1'b0;
   logic [DW-1:0] core_pcm_in_data;
   logic core_pcm_in_valid;
   logic core_pcm_put = 1'b0;
   logic [DW-1:0] core_pcm_out_data = '0;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   spch_host_buf #(.DW(DW), .DEPTH(DEPTH)) dut (.*);

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [DW-1:0] pat(input int i);
      return DW'(32'hA5C3 ^ (i * 32'h1357) ^ (i << 11));
   endfunction

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic cvin_write(input logic [DW-1:0] w);
      host_cvin_wr = 1'b1; host_cvin_data = w;
      tick();
      host_cvin_wr = 1'b0;
   endtask

   task automatic take_word(input logic [DW-1:0] w, input string tag);
      for (int b = 0; b < DW; b++) begin
         chk(tag, {31'd0, core_cv_bit}, {31'd0, w[b]});
         core_cv_bit_take = 1'b1;
         tick();
         core_cv_bit_take = 1'b0;
      end
   endtask

   task automatic put_word(input logic [DW-1:0] w);
      for (int b = 0; b < DW; b++) begin
         core_cv_bit_put = 1'b1; core_cv_bit_in = w[b];
         tick();
         core_cv_bit_put = 1'b0;
      end
   endtask

   task automatic cvout_read(input logic [DW-1:0] exp, input string tag);
      chk(tag, 32'(host_cvout_data), 32'(exp));
      host_cvout_rd = 1'b1;
      tick();
      host_cvout_rd = 1'b0;
   endtask

   task automatic stat_read(input logic frz);
      freeze = frz; host_stat_rd = 1'b1;
      tick();
      host_stat_rd = 1'b0; freeze = 1'b0;
   endtask

   task automatic sweep_cfg(input string tag);
      for (int c = 0; c < 64; c++) begin
         logic pi, ci, dpi, dpo, dci, dco;
         logic [4:0] exp;
         {pi, ci, dpi, dpo, dci, dco} = 6'(c);
         if (pi && (dpi || dpo)) continue;
         if (ci && (dci || dco)) continue;
         cfg_pcm_irq_en = pi; cfg_cv_irq_en = ci;
         cfg_dma_pcm_in_en = dpi; cfg_dma_pcm_out_en = dpo;
         cfg_dma_cv_in_en = dci; cfg_dma_cv_out_en = dco;
         #1;
         exp[4] = (host_stat[0] & pi) | ((host_stat[1] | host_stat[2]) & ci);
         exp[3] = host_stat[0] & dpi;
         exp[2] = host_stat[0] & dpo;
         exp[1] = host_stat[1] & dci;
         exp[0] = host_stat[2] & dco;
         chk(tag, {27'd0, irq, dma_pcm_in_req, dma_pcm_out_req, dma_cv_in_req, dma_cv_out_req},
             {27'd0, exp});
         tick();
      end
      {cfg_pcm_irq_en, cfg_cv_irq_en, cfg_dma_pcm_in_en,
       cfg_dma_pcm_out_en, cfg_dma_cv_in_en, cfg_dma_cv_out_en} = '0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL R12 watchdog expired actual=%0d expected=%0d", 0, 1);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (4) tick();
      rst_n = 1'b1;
      tick();

      // R12 reset state
      chk("R12 status", 32'(host_stat), 0);
      chk("R12 requests", {27'd0, irq, dma_pcm_in_req, dma_pcm_out_req, dma_cv_in_req, dma_cv_out_req}, 0);
      chk("R12 input queue empty", {31'd0, core_cv_bit_valid}, 0);
      chk("R12 pcm in valid", {31'd0, core_pcm_in_valid}, 0);
      chk("R5 pcm out zero after reset", 32'(host_pcmout_data), 0);

      // R1 fill input queue, one extra write is dropped; R2 LSB-first bits
      for (int i = 0; i < DEPTH + 1; i++) cvin_write(pat(i));
      for (int i = 0; i < DEPTH; i++) begin
         chk("R1 word present", {31'd0, core_cv_bit_valid}, 1);
         take_word(pat(i), "R2 bit order");
      end
      chk("R1 overflow word dropped", {31'd0, core_cv_bit_valid}, 0);
      chk("R6 input-empty flag", 32'(host_stat), 32'b010);

      // R7 read clears
      stat_read(1'b0);
      chk("R7 cleared by read", 32'(host_stat), 0);

      // R3 / R6 output queue fill, extra word dropped
      for (int i = 0; i < DEPTH + 1; i++) begin
         put_word(pat(100 + i));
         if (i == DEPTH - 2) chk("R6 full flag not early", 32'(host_stat), 0);
      end
      chk("R6 output-full flag", 32'(host_stat), 32'b100);
      stat_read(1'b1);
      chk("R9 frozen read keeps flag", 32'(host_stat), 32'b100);
      stat_read(1'b0);
      chk("R7 unfrozen read clears", 32'(host_stat), 0);
      for (int i = 0; i < DEPTH; i++) cvout_read(pat(100 + i), "R3 output order");
      host_cvout_rd = 1'b1; tick(); host_cvout_rd = 1'b0;
      put_word(pat(200));
      cvout_read(pat(200), "R3 empty read harmless");

      // R8 freeze stalls bit traffic
      cvin_write(pat(300));
      freeze = 1'b1;
      core_cv_bit_take = 1'b1;
      repeat (5) tick();
      core_cv_bit_take = 1'b0;
      core_cv_bit_put = 1'b1; core_cv_bit_in = 1'b1;
      repeat (20) tick();
      core_cv_bit_put = 1'b0; freeze = 1'b0;
      chk("R8 input word kept", {31'd0, core_cv_bit_valid}, 1);
      take_word(pat(300), "R8 bits start at 0 after freeze");
      put_word(pat(301));
      cvout_read(pat(301), "R8 frozen puts ignored");
      stat_read(1'b0);

      // R4 PCM input double buffer
      host_pcmin_wr = 1'b1; host_pcmin_data = 16'h1111; tick(); host_pcmin_wr = 1'b0;
      chk("R4 not yet visible", {31'd0, core_pcm_in_valid}, 0);
      tick();
      chk("R4 first sample", {15'd0, core_pcm_in_valid, core_pcm_in_data}, {15'd0, 1'b1, 16'h1111});
      chk("R6 pcm flag on input advance", 32'(host_stat), 32'b001);
      host_pcmin_wr = 1'b1; host_pcmin_data = 16'h2222; tick(); host_pcmin_wr = 1'b0;
      tick();
      chk("R4 second sample waits", 32'(core_pcm_in_data), 32'h1111);
      core_pcm_take = 1'b1; tick(); core_pcm_take = 1'b0;
      chk("R4 second sample after take", {15'd0, core_pcm_in_valid, core_pcm_in_data}, {15'd0, 1'b1, 16'h2222});
      freeze = 1'b1; core_pcm_take = 1'b1; tick(); core_pcm_take = 1'b0; freeze = 1'b0;
      chk("R8 frozen take ignored", {31'd0, core_pcm_in_valid}, 1);
      stat_read(1'b0);

      // R5 PCM output double buffer
      core_pcm_put = 1'b1; core_pcm_out_data = 16'h3333; tick(); core_pcm_put = 1'b0;
      tick();
      chk("R5 first sample", 32'(host_pcmout_data), 32'h3333);
      chk("R6 pcm flag on output advance", 32'(host_stat), 32'b001);
      core_pcm_put = 1'b1; core_pcm_out_data = 16'h4444; tick(); core_pcm_put = 1'b0;
      tick();
      chk("R5 second sample waits", 32'(host_pcmout_data), 32'h3333);
      host_pcmout_rd = 1'b1; tick(); host_pcmout_rd = 1'b0;
      chk("R5 second sample after read", 32'(host_pcmout_data), 32'h4444);
      freeze = 1'b1; core_pcm_put = 1'b1; core_pcm_out_data = 16'h5555; tick();
      core_pcm_put = 1'b0; host_pcmout_rd = 1'b1; tick(); host_pcmout_rd = 1'b0;
      freeze = 1'b0; tick(); tick();
      chk("R8 frozen pcm put ignored", 32'(host_pcmout_data), 32'h4444);

      // R10 / R11 sweep with all flags set, then clear
      cvin_write(pat(400));
      take_word(pat(400), "R2 bit order");
      for (int i = 0; i < DEPTH; i++) put_word(pat(500 + i));
      chk("R6 all flags set", 32'(host_stat), 32'b111);
      sweep_cfg("R10 R11 flags set");
      stat_read(1'b0);
      chk("R7 all cleared", 32'(host_stat), 0);
      sweep_cfg("R10 R11 flags clear");

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule